// File: doc/BRIEF.md
# Pin-Numbered Edge Interrupt Controller

This block turns transitions on general-purpose input pins into interrupt requests. It serves sixteen interrupt lines, and each line is tied to one pin number. Several GPIO ports each offer a pin with that number, and a per-line port selector decides which of them feeds the line. Because each line has only one selector, two ports cannot both raise the same line at the same time.

Every pin passes through a two-flop synchroniser. The controller then compares the selected pin's current sample with the previous one. Enable bits for the rising and falling directions decide which transitions set a line's sticky pending flag. Software clears a pending flag by writing a one to its bit.

Each line also has an interrupt-enable bit. It gates only the outputs, so a line whose enable is off still records its pending flag. Lines 0 to 4 each drive their own request output. Lines 5 to 9 are ORed onto a shared output, and lines 10 to 15 onto a second shared output. A handler on a shared output reads the pending register to find which line fired. A request stays asserted for as long as its line is pending and enabled.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, every register reads zero, every line selects port 0, and all request outputs are low.
- R2: On a line whose rising enable (address 0, bit n) is set, a 0-to-1 change on the selected pin sets pending bit n (address 3). The flag is visible three clock edges after the pin changes.
- R3: On a line whose falling enable (address 1, bit n) is set, a 1-to-0 change on the selected pin sets pending bit n.
- R4: A transition in a direction whose enable is clear leaves the pending flag at zero.
- R5: With both enables set on a line, a transition in either direction sets its pending flag.
- R6: Writing to address 3 clears exactly the pending bits written as one. Bits written as zero are left unchanged.
- R7: If a selected edge and a write-one clear of the same bit reach the pending register on the same clock edge, the bit stays set.
- R8: Line n watches only pin n of the port held in its 4-bit selector field. The field for line n sits at bits 4(n mod 8) to 4(n mod 8)+3 of address 4 for lines 0 to 7, and of address 5 for lines 8 to 15. Pins of other ports have no effect on the line.
- R9: Rewriting a line's selector never sets its pending flag by itself, even when the newly selected pin's level differs from the old one.
- R10: The interrupt-enable bits (address 2, bit n) gate only the request outputs. A line whose enable is off still latches its pending flag, and the request appears as soon as the enable is set.
- R11: irq_line[k] carries line k for k from 0 to 4. irq_grp_a is the OR of lines 5 to 9, and irq_grp_b is the OR of lines 10 to 15, each line counted only when both pending and enabled.
- R12: A request output stays high while its pending flag is set and falls once the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPORTS*16 | Raw GPIO pins; port p pin n is bit p*16+n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_line | output | 5 | Dedicated requests for lines 0 to 4 |
| irq_grp_a | output | 1 | Shared request for lines 5 to 9 |
| irq_grp_b | output | 1 | Shared request for lines 10 to 15 |

## Verification
The hardest case to reach is a new edge and a software clear of the same bit landing on the same clock edge. Reaching it requires counting the two synchroniser flops and the edge register exactly. The stimulus first leaves line 12 pending. It then raises the selected pin, and drives the clear write in the cycle that follows the second clock edge after the pin change, so the clear and the edge meet in the pending register together. A second delicate case is switching a selector onto a pin whose level differs from the old pin's. That case is reached by parking a high level on an unselected port before the switch and checking that nothing latches.

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int NPORTS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS*16-1:0]   pin_in,
  input  logic                   bus_we,
  input  logic [2:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [4:0]             irq_line,
  output logic                   irq_grp_a,
  output logic                   irq_grp_b
);
  localparam int NL = 16;
  localparam int SW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int FW = 4;

  logic [NPORTS*NL-1:0] s1_q, s2_q;
  logic [NL-1:0] rise_q, fall_q, ien_q, pend_q, prev_q;
  logic [NL-1:0] cur, nxt, clr, act;
  logic [SW-1:0] sel_q [NL];
  logic [SW-1:0] sel_d [NL];
  logic [2*NL*FW/2-1:0] sel_pack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end

  for (genvar n = 0; n < NL; n++) begin : g_line
    localparam logic [2:0] SEL_ADDR = 3'(4 + n / 8);
    localparam int FLO = FW * (n % 8);
    logic cur_b, nxt_b;

    always_comb begin
      sel_d[n] = sel_q[n];
      if (bus_we && bus_addr == SEL_ADDR) sel_d[n] = bus_wdata[FLO +: SW];
    end

    always_comb begin
      cur_b = 1'b0;
      nxt_b = 1'b0;
      for (int p = 0; p < NPORTS; p++) begin
        if (sel_q[n] == SW'(p)) cur_b = s2_q[p*NL+n];
        if (sel_d[n] == SW'(p)) nxt_b = s2_q[p*NL+n];
      end
    end

    assign cur[n] = cur_b;
    assign nxt[n] = nxt_b;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sel_q[n] <= '0;
      else        sel_q[n] <= sel_d[n];
  end

  assign clr = (bus_we && bus_addr == 3'd3) ? bus_wdata[NL-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      ien_q  <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= nxt;
      pend_q <= (pend_q & ~clr) | (cur & ~prev_q & rise_q) | (~cur & prev_q & fall_q);
      if (bus_we) begin
        case (bus_addr)
          3'd0: rise_q <= bus_wdata[NL-1:0];
          3'd1: fall_q <= bus_wdata[NL-1:0];
          3'd2: ien_q  <= bus_wdata[NL-1:0];
          default: ;
        endcase
      end
    end

  always_comb begin
    sel_pack = '0;
    for (int n = 0; n < NL; n++) sel_pack[FW*n +: SW] = sel_q[n];
  end

  always_comb
    case (bus_addr)
      3'd0:    bus_rdata = 32'(rise_q);
      3'd1:    bus_rdata = 32'(fall_q);
      3'd2:    bus_rdata = 32'(ien_q);
      3'd3:    bus_rdata = 32'(pend_q);
      3'd4:    bus_rdata = sel_pack[31:0];
      3'd5:    bus_rdata = sel_pack[63:32];
      default: bus_rdata = '0;
    endcase

  assign act       = pend_q & ien_q;
  assign irq_line  = act[4:0];
  assign irq_grp_a = |act[9:5];
  assign irq_grp_b = |act[15:10];
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [15:0] pend,
  input logic [15:0] rise,
  input logic [15:0] fall,
  input logic [15:0] ien,
  input logic [4:0]  irq_line,
  input logic        irq_grp_a,
  input logic        irq_grp_b
);
  logic [15:0] clr_c;
  assign clr_c = (bus_we && bus_addr == 3'd3) ? bus_wdata[15:0] : 16'h0;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend == 16'h0 && irq_line == 5'h0 && !irq_grp_a && !irq_grp_b));

  p_new_pend_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~($past(rise) | $past(fall))) == 16'h0));

  p_pend_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~clr_c)) == $past(pend & ~clr_c)));

  p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 16'h0) |-> (irq_line == 5'h0 && !irq_grp_a && !irq_grp_b));

  p_grp_a_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grp_a |-> (pend[9:5] != 5'h0));

  p_grp_b_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_grp_b |-> (pend[15:10] != 6'h0));

  p_line_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line != 5'h0) |-> ((irq_line & ~pend[4:0]) == 5'h0));
endmodule

bind pin_edge_irq pin_edge_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pend(pend_q), .rise(rise_q), .fall(fall_q),
  .ien(ien_q), .irq_line(irq_line), .irq_grp_a(irq_grp_a), .irq_grp_b(irq_grp_b)
);

// File: tb/pin_edge_irq_tb_top.sv
`timescale 1ns/1ps
module pin_edge_irq_tb_top;
  localparam int NPORTS = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NPORTS*16-1:0] pin_in = '0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0] irq_line;
  logic irq_grp_a, irq_grp_b;

  always #2.5 clk = ~clk;

  pin_edge_irq #(.NPORTS(NPORTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .irq_grp_a(irq_grp_a), .irq_grp_b(irq_grp_b)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t it;
  logic [31:0] got;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(negedge clk)
    if (q.size() > 0) begin
      it = q.pop_front();
      got = (it.kind == 0) ? bus_rdata : {25'd0, irq_grp_b, irq_grp_a, irq_line};
      n_chk++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
      end
    end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    q.push_back('{0, v, tag});
    @(negedge clk); #1;
  endtask

  task automatic exp_irq(input logic [6:0] v, input string tag);
    @(posedge clk); #1;
    q.push_back('{1, 32'(v), tag});
    @(negedge clk); #1;
  endtask

  task automatic pin(input int idx, input logic v);
    @(posedge clk); #1;
    pin_in[idx] = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int a = 0; a < 6; a++) exp_rd(3'(a), 32'h0, "R1 reset register");
    exp_irq(7'h00, "R1 reset outputs");

    // R2 rising on line 0, enable off first (R10)
    wr(3'd0, 32'h0001);
    pin(0, 1'b1);
    exp_rd(3'd3, 32'h0001, "R2 rising sets pending");
    exp_irq(7'h00, "R10 masked line quiet");
    wr(3'd2, 32'h0001);
    exp_irq(7'h01, "R10 request after enable");
    repeat (3) @(posedge clk);
    exp_irq(7'h01, "R12 request held");
    wr(3'd3, 32'h0001);
    exp_rd(3'd3, 32'h0000, "R6 cleared by write one");
    exp_irq(7'h00, "R12 request drops");

    // R4 line 1 with no enables
    pin(1, 1'b1);
    pin(1, 1'b0);
    exp_rd(3'd3, 32'h0000, "R4 disabled edges ignored");

    // R3 falling on line 2
    wr(3'd1, 32'h0004);
    pin(2, 1'b1);
    exp_rd(3'd3, 32'h0000, "R3 rising ignored on fall-only line");
    pin(2, 1'b0);
    exp_rd(3'd3, 32'h0004, "R3 falling sets pending");

    // R5 both edges on line 3
    wr(3'd0, 32'h0008);
    wr(3'd1, 32'h000C);
    pin(3, 1'b1);
    exp_rd(3'd3, 32'h000C, "R5 rising on dual line");
    wr(3'd3, 32'h0004);
    exp_rd(3'd3, 32'h0008, "R6 selective clear");
    wr(3'd3, 32'h0008);
    pin(3, 1'b0);
    exp_rd(3'd3, 32'h0008, "R5 falling on dual line");
    wr(3'd3, 32'hFFFF);
    exp_rd(3'd3, 32'h0000, "R6 clear all");

    // R8 line 6 from port 2
    wr(3'd0, 32'h0040);
    wr(3'd1, 32'h0000);
    wr(3'd2, 32'h0040);
    wr(3'd4, 32'h0200_0000);
    exp_rd(3'd4, 32'h0200_0000, "R8 selector readback");
    pin(6, 1'b1);
    pin(16 + 6, 1'b1);
    exp_rd(3'd3, 32'h0000, "R8 other ports ignored");
    pin(32 + 6, 1'b1);
    exp_rd(3'd3, 32'h0040, "R8 selected port edge");
    exp_irq(7'h20, "R11 line 6 on shared group a");
    wr(3'd3, 32'h0040);
    exp_irq(7'h00, "R12 group a drops");

    // R9 reselect line 12 onto a high pin
    wr(3'd0, 32'h1000);
    wr(3'd1, 32'h1000);
    wr(3'd2, 32'h0000);
    pin(48 + 12, 1'b1);
    exp_rd(3'd3, 32'h0000, "R8 unselected port 3 ignored");
    wr(3'd5, 32'h0003_0000);
    repeat (4) @(posedge clk);
    exp_rd(3'd3, 32'h0000, "R9 reselect makes no edge");
    exp_rd(3'd5, 32'h0003_0000, "R8 high selector readback");
    pin(48 + 12, 1'b0);
    exp_rd(3'd3, 32'h1000, "R9 new pin live after reselect");
    wr(3'd2, 32'h1000);
    exp_irq(7'h40, "R11 line 12 on shared group b");

    // R7 edge and clear meet on the same clock edge
    @(posedge clk); #1;
    pin_in[48 + 12] = 1'b1;
    @(posedge clk);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h1000;
    @(posedge clk); #1;
    bus_we = 1'b0;
    exp_rd(3'd3, 32'h1000, "R7 edge wins over clear");
    exp_irq(7'h40, "R7 request kept");
    wr(3'd3, 32'h1000);
    exp_rd(3'd3, 32'h0000, "R6 clear without edge");
    exp_irq(7'h00, "R12 group b drops");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule